// File: doc/BRIEF.md
# Page-Split Branch Target Generator

This block forms the target of a short branch from the current program counter and the displacement field of the branch instruction. The program counter names an instruction as a bundle address plus a two-bit slot: three 42-bit instructions share one 128-bit bundle, so the slot runs 0, 1, 2 and then the bundle address steps. The counter splits at a page boundary. The bits above the boundary are the page number. The bits below it are the position inside the page: the bundle within the page and the slot.

The displacement splits at the same place. Its upper field is a signed count of pages, and only this field is added to the page number of the program counter. Its lower field is an absolute position inside the target page and becomes the low part of the target without change. No carry ever crosses the boundary. The adder therefore spans only the page-number bits. A branch target-buffer index comes straight from the raw displacement bits, so a lookup can start before the page sum settles.

A parameter selects between a purely combinational result and a version with one register stage, in which a valid strobe launches the result one cycle later.

Top module: `hybrid_branch_target`

## Requirements
- R1: The target bits below the page boundary (`target[PAGE_OFS_W-1:0]`) equal `disp[PAGE_OFS_W-1:0]` whatever the in-page bits of `pc` are.
- R2: The target page number (`target[PC_W-1:PAGE_OFS_W]`) equals the page number of `pc` plus the two's-complement value of `disp[REL_W+PAGE_OFS_W-1:PAGE_OFS_W]`.
- R3: The page sum wraps modulo 2^(PC_W-PAGE_OFS_W) in both directions. No flag or trap is raised on wrap.
- R4: `btb_index` equals `disp[2+IDX_W-1:2]`, the bundle bits of the absolute field just above the 2-bit slot in `disp[1:0]`.
- R5: `illegal_target` is 1 exactly when the slot `disp[1:0]` is 3. The computed target is still driven in that case.
- R6: With REG_OUT=1, a cycle with `in_valid` high produces `out_valid` high and that cycle's results on the following cycle. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R7: With REG_OUT=1, `target`, `btb_index` and `illegal_target` keep their values through cycles with `in_valid` low, even while `pc` and `disp` change.
- R8: With REG_OUT=1, while `rst_n` is low all outputs read 0.
- R9: With REG_OUT=0, `out_valid` follows `in_valid` and the results follow `pc` and `disp` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The pc and disp inputs carry a branch to resolve |
| pc | input | PC_W | Program counter: page number, then bundle in page, then 2-bit slot |
| disp | input | REL_W+PAGE_OFS_W | Displacement: signed page count above, absolute in-page position below |
| out_valid | output | 1 | The result outputs are valid |
| target | output | PC_W | Branch target in program-counter format |
| btb_index | output | IDX_W | Target-buffer index taken from the raw displacement |
| illegal_target | output | 1 | The absolute field names the nonexistent slot 3 |

## Verification
The hardest case to reach from the ports is the page sum wrapping across the top and the bottom of the page space. With realistic widths this needs the page number near its extremes together with a relative count of the matching sign. The bench therefore uses a reduced configuration with 64 pages and a 3-bit relative field. It sweeps every page number against every relative count and every absolute field, so both wrap directions and every slot value, including the illegal one, occur. Each vector sets the in-page bits of `pc` to an unrelated pattern, which shows that these bits never leak into the target.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
   localparam int SLOT_W = 2;

   typedef enum logic [SLOT_W-1:0] {
      SLOT_0   = 2'd0,
      SLOT_1   = 2'd1,
      SLOT_2   = 2'd2,
      SLOT_BAD = 2'd3
   } slot_e;

   function automatic logic slot_is_bad(input logic [SLOT_W-1:0] s);
      return slot_e'(s) == SLOT_BAD;
   endfunction
endpackage

// File: rtl/hbt_page_add.sv
module hbt_page_add #(
   parameter int PAGE_W = 28,
   parameter int REL_W  = 4
) (
   input  logic [PAGE_W-1:0] page_in,
   input  logic [REL_W-1:0]  rel,
   output logic [PAGE_W-1:0] page_out
);
   logic [PAGE_W-1:0] rel_ext;

   generate
      if (PAGE_W > REL_W) begin : g_sext
         assign rel_ext = {{(PAGE_W-REL_W){rel[REL_W-1]}}, rel};
      end else begin : g_same
         assign rel_ext = rel[PAGE_W-1:0];
      end
   endgenerate

   // Modulo sum: the carry out of the top bit is dropped on purpose.
   assign page_out = page_in + rel_ext;
endmodule

// File: rtl/hbt_inpage_decode.sv
module hbt_inpage_decode
   import hbt_pkg::*;
#(
   parameter int OFS_W = 12,
   parameter int IDX_W = 6
) (
   input  logic [OFS_W-1:0] abs_field,
   output logic [IDX_W-1:0] idx,
   output logic             bad_slot
);
   localparam int BUNDLE_W = OFS_W - SLOT_W;

   generate
      if (IDX_W > BUNDLE_W) begin : g_bad_idx
         $error("hbt_inpage_decode: index wider than the bundle field");
      end
   endgenerate

   assign idx      = abs_field[SLOT_W +: IDX_W];
   assign bad_slot = slot_is_bad(abs_field[SLOT_W-1:0]);
endmodule

// File: rtl/hbt_out_stage.sv
module hbt_out_stage #(
   parameter int PC_W    = 40,
   parameter int IDX_W   = 6,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_d,
   input  logic [PC_W-1:0]  tgt_d,
   input  logic [IDX_W-1:0] idx_d,
   input  logic             bad_d,
   output logic             v_q,
   output logic [PC_W-1:0]  tgt_q,
   output logic [IDX_W-1:0] idx_q,
   output logic             bad_q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q   <= 1'b0;
               tgt_q <= '0;
               idx_q <= '0;
               bad_q <= 1'b0;
            end else begin
               v_q <= v_d;
               if (v_d) begin
                  tgt_q <= tgt_d;
                  idx_q <= idx_d;
                  bad_q <= bad_d;
               end
            end
         end
      end else begin : g_comb
         assign v_q   = v_d;
         assign tgt_q = tgt_d;
         assign idx_q = idx_d;
         assign bad_q = bad_d;
      end
   endgenerate
endmodule

// File: rtl/hybrid_branch_target.sv
module hybrid_branch_target #(
   parameter int PC_W       = 40,
   parameter int PAGE_OFS_W = 12,
   parameter int REL_W      = 4,
   parameter int IDX_W      = 6,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [PC_W-1:0]             pc,
   input  logic [REL_W+PAGE_OFS_W-1:0] disp,
   output logic                        out_valid,
   output logic [PC_W-1:0]             target,
   output logic [IDX_W-1:0]            btb_index,
   output logic                        illegal_target
);
   localparam int PAGE_W = PC_W - PAGE_OFS_W;
   localparam int DISP_W = REL_W + PAGE_OFS_W;

   generate
      if (REL_W < 2) begin : g_chk_rel
         $error("hybrid_branch_target: relative field needs at least 2 bits");
      end
      if (PAGE_W < REL_W) begin : g_chk_page
         $error("hybrid_branch_target: page number narrower than relative field");
      end
      if (PAGE_OFS_W < hbt_pkg::SLOT_W + 1) begin : g_chk_ofs
         $error("hybrid_branch_target: page must hold at least two bundles");
      end
   endgenerate

   logic [PAGE_W-1:0] page_sum;
   logic [IDX_W-1:0]  idx_c;
   logic              bad_c;
   logic [PC_W-1:0]   tgt_c;

   hbt_page_add #(.PAGE_W(PAGE_W), .REL_W(REL_W)) u_add (
      .page_in (pc[PC_W-1:PAGE_OFS_W]),
      .rel     (disp[DISP_W-1:PAGE_OFS_W]),
      .page_out(page_sum)
   );

   hbt_inpage_decode #(.OFS_W(PAGE_OFS_W), .IDX_W(IDX_W)) u_dec (
      .abs_field(disp[PAGE_OFS_W-1:0]),
      .idx      (idx_c),
      .bad_slot (bad_c)
   );

   assign tgt_c = {page_sum, disp[PAGE_OFS_W-1:0]};

   hbt_out_stage #(.PC_W(PC_W), .IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .v_d  (in_valid),
      .tgt_d(tgt_c),
      .idx_d(idx_c),
      .bad_d(bad_c),
      .v_q  (out_valid),
      .tgt_q(target),
      .idx_q(btb_index),
      .bad_q(illegal_target)
   );
endmodule

// File: rtl/hybrid_branch_target_chk.sv
module hybrid_branch_target_chk #(
   parameter int PC_W       = 40,
   parameter int PAGE_OFS_W = 12,
   parameter int REL_W      = 4,
   parameter int IDX_W      = 6,
   parameter bit REG_OUT    = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [PC_W-1:0]             pc,
   input logic [REL_W+PAGE_OFS_W-1:0] disp,
   input logic                        out_valid,
   input logic [PC_W-1:0]             target,
   input logic [IDX_W-1:0]            btb_index,
   input logic                        illegal_target
);
   localparam int PAGE_W = PC_W - PAGE_OFS_W;
   localparam int DISP_W = REL_W + PAGE_OFS_W;

   logic [PAGE_W-1:0] exp_page;
   assign exp_page = pc[PC_W-1:PAGE_OFS_W]
                   + PAGE_W'($signed(disp[DISP_W-1:PAGE_OFS_W]));

   generate
      if (REG_OUT) begin : g_seq
         a_r1_inpage_copy: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> target[PAGE_OFS_W-1:0] == $past(disp[PAGE_OFS_W-1:0]));
         a_r2_r3_page_sum: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> target[PC_W-1:PAGE_OFS_W] == $past(exp_page));
         a_r4_index: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> btb_index == $past(disp[2 +: IDX_W]));
         a_r5_bad_slot: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> illegal_target == ($past(disp[1:0]) == 2'd3));
         a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid && rst_n));
         a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!in_valid) |-> ($stable(target) && $stable(btb_index)
                                  && $stable(illegal_target)));
      end else begin : g_comb
         a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
         a_r1_inpage_now: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> target[PAGE_OFS_W-1:0] == disp[PAGE_OFS_W-1:0]);
         a_r2_page_now: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> target[PC_W-1:PAGE_OFS_W] == exp_page);
         a_r5_bad_now: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> illegal_target == (disp[1:0] == 2'd3));
      end
   endgenerate
endmodule

bind hybrid_branch_target hybrid_branch_target_chk #(
   .PC_W(PC_W), .PAGE_OFS_W(PAGE_OFS_W), .REL_W(REL_W),
   .IDX_W(IDX_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .disp(disp),
   .out_valid(out_valid), .target(target), .btb_index(btb_index),
   .illegal_target(illegal_target)
);

// File: tb/hybrid_branch_target_test.sv
`timescale 1ns/1ps
module hybrid_branch_target_test;
   localparam int W  = 12;
   localparam int P  = 6;
   localparam int R  = 3;
   localparam int IX = 3;
   localparam int PG = W - P;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [W-1:0]   pc = '0;
   logic [R+P-1:0] disp = '0;

   logic          ov, ill, ov_c, ill_c;
   logic [W-1:0]  tgt, tgt_c;
   logic [IX-1:0] idx, idx_c;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   hybrid_branch_target #(.PC_W(W), .PAGE_OFS_W(P), .REL_W(R), .IDX_W(IX),
                          .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .disp(disp),
      .out_valid(ov), .target(tgt), .btb_index(idx), .illegal_target(ill));

   hybrid_branch_target #(.PC_W(W), .PAGE_OFS_W(P), .REL_W(R), .IDX_W(IX),
                          .REG_OUT(1'b0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .disp(disp),
      .out_valid(ov_c), .target(tgt_c), .btb_index(idx_c), .illegal_target(ill_c));

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [W-1:0]  e_tgt, last_tgt;
      logic [IX-1:0] e_idx, last_idx;
      logic          e_ill, last_ill;
      bit            have_prev;
      have_prev = 0;
      last_tgt = '0; last_idx = '0; last_ill = 0;

      // R8: reset state with inputs active
      in_valid = 1'b1; pc = 12'hABC; disp = 9'h1FF;
      repeat (3) @(negedge clk);
      check(ov == 0,  "R8 out_valid", ov, 0);
      check(tgt == 0, "R8 target", tgt, 0);
      check(idx == 0, "R8 btb_index", idx, 0);
      check(ill == 0, "R8 illegal", ill, 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ov == 0, "R6 idle out_valid", ov, 0);

      for (int page = 0; page < (1 << PG); page++) begin
         for (int rel = 0; rel < (1 << R); rel++) begin
            for (int ab = 0; ab < (1 << P); ab++) begin
               int rs, ep;
               @(negedge clk);
               if (have_prev) begin
                  check(ov == 1, "R6 out_valid", ov, 1);
                  check(tgt == last_tgt, "R1 R2 R3 reg target", tgt, last_tgt);
                  check(idx == last_idx, "R4 reg index", idx, last_idx);
                  check(ill == last_ill, "R5 reg illegal", ill, last_ill);
               end
               rs = (rel >= (1 << (R-1))) ? rel - (1 << R) : rel;
               ep = (page + rs + (1 << PG)) % (1 << PG);
               in_valid = 1'b1;
               pc   = W'((page << P) | ((page * 37 + rel * 11 + ab * 5) & ((1 << P) - 1)));
               disp = (R+P)'((rel << P) | ab);
               e_tgt = W'((ep << P) | ab);
               e_idx = IX'(ab >> 2);
               e_ill = ((ab & 3) == 3);
               #1;
               check(ov_c == 1, "R9 comb out_valid", ov_c, 1);
               check(tgt_c[P-1:0] == e_tgt[P-1:0], "R1 comb in-page", tgt_c, e_tgt);
               check(tgt_c[W-1:P] == e_tgt[W-1:P], "R2 R3 comb page", tgt_c, e_tgt);
               check(idx_c == e_idx, "R4 comb index", idx_c, e_idx);
               check(ill_c == e_ill, "R5 comb illegal", ill_c, e_ill);
               last_tgt = e_tgt; last_idx = e_idx; last_ill = e_ill;
               have_prev = 1;
            end
         end
      end

      // Last vector, then R7 hold with changing inputs
      @(negedge clk);
      check(tgt == last_tgt, "R1 R2 reg last target", tgt, last_tgt);
      in_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         pc = W'(k * 613); disp = (R+P)'(k * 97 + 2);
         @(negedge clk);
         check(ov == 0, "R6 out_valid low", ov, 0);
         check(tgt == last_tgt, "R7 target hold", tgt, last_tgt);
         check(idx == last_idx, "R7 index hold", idx, last_idx);
         check(ill == last_ill, "R7 illegal hold", ill, last_ill);
         check(ov_c == 0, "R9 comb valid low", ov_c, 0);
      end

      // R8: reset again clears loaded state
      rst_n = 1'b0;
      #1;
      check(tgt == 0 && ov == 0, "R8 reset clear", tgt, 0);
      summary();
   end
endmodule